// File: doc/BRIEF.md
# Ethernet port LED event controller

This block drives the status lamps of a group of Ethernet ports. The default is five ports with four lamps each, twenty lamps in all. Each lamp index is `port*4 + lamp`. That index is also the bit position on the `led_pin` bus. Each lamp takes four 16-bit settings:

- a steady-state word, which picks the link conditions that light the lamp and also holds the enable and polarity bits;
- an activity word, which picks the traffic strobes that make the lamp flash;
- a lit time;
- a flash period.

A shared prescaler divides the clock into a duration tick. Both times count that tick. The default divide of 8192 gives about 41 µs per tick at 200 MHz, so a period of 0x61A is about 64 ms.

Each port has a select register with one bit per lamp. A lamp whose bit is set uses its own settings. A lamp whose bit is clear uses one shared default set. Software writes the settings through a simple word-wide write port and reads them back through a combinational read bus. A global flash-clear register holds every lamp's flash state at rest while it is nonzero. Software writes 0x1F to it and later writes 0 to release it.

When a selected activity strobe is seen, the lamp runs one flash period. It is lit for the first `lit time` ticks and dark for the rest. If another selected strobe arrives during the period, the next period follows without a gap. Otherwise the lamp returns to its steady link-condition result. Polarity is applied last. A disabled lamp drives its inactive level.

Top module: `led_event_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released, every `led_pin` bit is 1 and every register reads 0, until software changes a setting.
- R2: The address map is as follows. Addresses below 0x80 hold per-lamp settings at `index*4 + k`: k=0 steady word, k=1 activity word, k=2 lit time, k=3 flash period. Addresses 0x80+p (p < 5) hold the port select registers, which are 4 bits wide. Address 0x88 is flash-clear. Addresses 0x8C..0x8F hold the default set, in the same k order. Every mapped register reads back what was written. Unmapped addresses read 0 and ignore writes.
- R3: A write to a flash-period register (k=3, or 0x8F) also loads the matching lit-time register with the written value shifted right by one. A later write to the lit-time register overrides that value.
- R4: Bit 15 of the steady word enables the lamp, and bit 14 selects polarity (1 = active high). The pin is registered, so it shows the lamp state one clock after the inputs and settings that produce it. A disabled lamp drives the inverse of its polarity bit.
- R5: The steady-word event bits are: 6 = always on, 5 = link up half duplex, 4 = link up full duplex, 3 = link down, 2 = link up at 10M, 1 = link up at 100M, 0 = link up at 1000M. Port speed codes are 0 = 10M, 1 = 100M, 2 = 1000M, 3 = none.
- R6: The activity-word bits are: 9 = flash continuously, 5/4 = rx/tx at 10M, 3/2 = rx/tx at 100M, 1/0 = rx/tx at 1000M. A strobe counts only while its port is up at the matching speed.
- R7: A selected strobe on an idle lamp starts a period on the next clock. The lamp is lit while the tick count is below the lit time. The period ends on the tick at which the count reaches the flash period minus one. If a selected strobe occurred during the period, or occurs in its last cycle, the next period starts at once. Otherwise the lamp goes idle.
- R8: A flash period of 0 keeps the lamp idle, so it shows the steady result even with bit 9 set.
- R9: A select bit of 1 gives the lamp its own settings. A select bit of 0 gives it the default set.
- R10: While flash-clear is nonzero, every lamp's flash state is held idle and the lamp shows its steady result. Flashing resumes after clear returns to 0.
- R11: The duration tick fires once every TICK_DIV clocks and is shared by all lamps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| link_up | input | NUM_PORTS | Per-port link up |
| full_dup | input | NUM_PORTS | Per-port full duplex |
| speed | input | 2*NUM_PORTS | Per-port speed code, port p at [2p+1:2p] |
| tx_act | input | NUM_PORTS | Per-port transmit activity strobe |
| rx_act | input | NUM_PORTS | Per-port receive activity strobe |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for reg_addr |
| led_pin | output | NUM_PORTS*LEDS_PER_PORT | Lamp pins, bit = port*4+lamp |

## Verification
Several events can land in the same cycle:

- an activity strobe can arrive on the clock where a duration tick closes a period;
- a flash-clear write can land while a period is running;
- a settings write can change the period under a running count.

The bench provokes these overlaps by driving random strobes, link states and settings for every lamp at a prescale of 4. It also issues forced-flash and clear writes at fixed points. A behavioural reference model applies the written rules in their stated order: the pin from the old state, then the flash state update, then the register write. That model is compared with all twenty pins on every clock.

// File: rtl/led_evt_pkg.sv
package led_evt_pkg;

  localparam int WORD_W        = 16;
  localparam int ON_EN_BIT     = 15;
  localparam int ON_POL_BIT    = 14;

  localparam logic [1:0] SPD_10   = 2'd0;
  localparam logic [1:0] SPD_100  = 2'd1;
  localparam logic [1:0] SPD_1000 = 2'd2;

  typedef struct packed {
    logic [WORD_W-1:0] on_w;
    logic [WORD_W-1:0] blk_w;
    logic [WORD_W-1:0] on_dur;
    logic [WORD_W-1:0] blk_dur;
  } led_cfg_t;

  // steady-state decision from link conditions (R5)
  function automatic logic steady_hit(input logic [WORD_W-1:0] w, input logic up,
                                      input logic fd, input logic [1:0] spd);
    logic [6:0] cond;
    cond[6] = 1'b1;
    cond[5] = up & ~fd;
    cond[4] = up & fd;
    cond[3] = ~up;
    cond[2] = up & (spd == SPD_10);
    cond[1] = up & (spd == SPD_100);
    cond[0] = up & (spd == SPD_1000);
    return |(w[6:0] & cond);
  endfunction

  // activity decision from traffic strobes (R6)
  function automatic logic flash_hit(input logic [WORD_W-1:0] w, input logic up,
                                     input logic [1:0] spd, input logic tx, input logic rx);
    logic [9:0] cond;
    cond    = '0;
    cond[9] = 1'b1;
    cond[5] = up & (spd == SPD_10)   & rx;
    cond[4] = up & (spd == SPD_10)   & tx;
    cond[3] = up & (spd == SPD_100)  & rx;
    cond[2] = up & (spd == SPD_100)  & tx;
    cond[1] = up & (spd == SPD_1000) & rx;
    cond[0] = up & (spd == SPD_1000) & tx;
    return |(w[9:0] & cond);
  endfunction

  // polarity and enable applied last (R4)
  function automatic logic pin_level(input logic en, input logic pol, input logic lit);
    return en ? (pol ? lit : ~lit) : ~pol;
  endfunction

  // lit time loaded alongside the flash period (R3)
  function automatic logic [WORD_W-1:0] half_of(input logic [WORD_W-1:0] d);
    return d >> 1;
  endfunction

endpackage

// File: rtl/led_tick_gen.sv
module led_tick_gen #(
  parameter int TICK_DIV = 8192
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

  logic [CW-1:0] pre_q;

  assign tick = (pre_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)    pre_q <= '0;
    else if (tick) pre_q <= '0;
    else           pre_q <= pre_q + 1'b1;
  end

  generate
    if (TICK_DIV > 1) begin : g_gap_chk
      // R11: two ticks never fall on consecutive clocks
      p_tick_gap_r11: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/led_regfile.sv
module led_regfile
  import led_evt_pkg::*;
#(
  parameter int NUM_PORTS     = 5,
  parameter int LEDS_PER_PORT = 4,
  parameter int ADDR_W        = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_we,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [WORD_W-1:0]   reg_wdata,
  output logic [WORD_W-1:0]   reg_rdata,
  output led_cfg_t [NUM_PORTS*LEDS_PER_PORT-1:0] eff_cfg,
  output logic                blink_clr
);
  localparam int NUM_LEDS = NUM_PORTS * LEDS_PER_PORT;
  localparam int IDX_W    = ADDR_W - 3;
  localparam int LOW_W    = ADDR_W - 1;
  localparam logic [LOW_W-1:0] CLR_OFS = LOW_W'(8);
  localparam logic [LOW_W-3:0] DFLT_GRP = (LOW_W-2)'(3);

  led_cfg_t [NUM_LEDS-1:0] cfg_q;
  led_cfg_t                dflt_q;
  logic [NUM_PORTS-1:0][LEDS_PER_PORT-1:0] sel_q;
  logic [WORD_W-1:0]       clr_q;

  logic              ctl_space;
  logic [IDX_W-1:0]  idx;
  logic [1:0]        kind;
  logic [LOW_W-1:0]  low;
  logic              dflt_hit;
  logic              dflt_bdur_wr;

  assign ctl_space    = reg_addr[ADDR_W-1];
  assign idx          = reg_addr[ADDR_W-2:2];
  assign kind         = reg_addr[1:0];
  assign low          = reg_addr[ADDR_W-2:0];
  assign dflt_hit     = ctl_space && (low[LOW_W-1:2] == DFLT_GRP);
  assign dflt_bdur_wr = reg_we && dflt_hit && (kind == 2'd3);
  assign blink_clr    = |clr_q;

  function automatic led_cfg_t apply_wr(input led_cfg_t c, input logic [1:0] k,
                                        input logic [WORD_W-1:0] d);
    led_cfg_t r;
    r = c;
    case (k)
      2'd0: r.on_w   = d;
      2'd1: r.blk_w  = d;
      2'd2: r.on_dur = d;
      default: begin
        r.blk_dur = d;
        r.on_dur  = half_of(d);
      end
    endcase
    return r;
  endfunction

  function automatic logic [WORD_W-1:0] pick(input led_cfg_t c, input logic [1:0] k);
    case (k)
      2'd0:    return c.on_w;
      2'd1:    return c.blk_w;
      2'd2:    return c.on_dur;
      default: return c.blk_dur;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      dflt_q <= '0;
      sel_q  <= '0;
      clr_q  <= '0;
    end else if (reg_we) begin
      if (!ctl_space) begin
        for (int i = 0; i < NUM_LEDS; i++)
          if (idx == IDX_W'(i)) cfg_q[i] <= apply_wr(cfg_q[i], kind, reg_wdata);
      end else begin
        for (int p = 0; p < NUM_PORTS; p++)
          if (low == LOW_W'(p)) sel_q[p] <= reg_wdata[LEDS_PER_PORT-1:0];
        if (low == CLR_OFS) clr_q <= reg_wdata;
        if (dflt_hit) dflt_q <= apply_wr(dflt_q, kind, reg_wdata);
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (!ctl_space) begin
      for (int i = 0; i < NUM_LEDS; i++)
        if (idx == IDX_W'(i)) reg_rdata = pick(cfg_q[i], kind);
    end else begin
      for (int p = 0; p < NUM_PORTS; p++)
        if (low == LOW_W'(p)) reg_rdata = WORD_W'(sel_q[p]);
      if (low == CLR_OFS) reg_rdata = clr_q;
      if (dflt_hit) reg_rdata = pick(dflt_q, kind);
    end
  end

  generate
    for (genvar g = 0; g < NUM_LEDS; g++) begin : g_eff
      assign eff_cfg[g] = sel_q[g / LEDS_PER_PORT][g % LEDS_PER_PORT] ? cfg_q[g] : dflt_q;
    end
  endgenerate

  // R3: a period write leaves half of it in the lit-time register
  p_half_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dflt_bdur_wr |=> (dflt_q.on_dur == ($past(reg_wdata) >> 1)));
endmodule

// File: rtl/led_lane.sv
module led_lane
  import led_evt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       clr,
  input  led_cfg_t   cfg,
  input  logic       up,
  input  logic       fd,
  input  logic [1:0] spd,
  input  logic       tx,
  input  logic       rx,
  output logic       pin
);
  logic              active_q, armed_q, pin_q;
  logic [WORD_W-1:0] cnt_q;
  logic              evt, lit, bdur_zero, period_end;

  logic unused_bits;
  assign unused_bits = ^{cfg.on_w[13:7], cfg.blk_w[15:10], cfg.blk_w[8:6]};

  assign evt        = flash_hit(cfg.blk_w, up, spd, tx, rx);
  assign bdur_zero  = (cfg.blk_dur == '0);
  assign period_end = tick && (cnt_q >= cfg.blk_dur - 1'b1);
  assign lit        = active_q ? (cnt_q < cfg.on_dur) : steady_hit(cfg.on_w, up, fd, spd);
  assign pin        = pin_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      armed_q  <= 1'b0;
      cnt_q    <= '0;
      pin_q    <= 1'b1;
    end else begin
      pin_q <= pin_level(cfg.on_w[ON_EN_BIT], cfg.on_w[ON_POL_BIT], lit);
      if (clr || bdur_zero) begin
        active_q <= 1'b0;
        armed_q  <= 1'b0;
        cnt_q    <= '0;
      end else if (!active_q) begin
        if (evt) begin
          active_q <= 1'b1;
          armed_q  <= 1'b0;
          cnt_q    <= '0;
        end
      end else begin
        if (evt) armed_q <= 1'b1;
        if (period_end) begin
          cnt_q   <= '0;
          armed_q <= 1'b0;
          if (!(armed_q || evt)) active_q <= 1'b0;
        end else if (tick) begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  // R10: the clear request forces the flash state idle
  p_clear_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !active_q);
  // R8: a zero period never lets the lane flash
  p_zero_period_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bdur_zero |=> !active_q);
  // R7: a strobe on an idle lane opens a period at count zero
  p_idle_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!active_q && evt && !clr && !bdur_zero) |=> (active_q && cnt_q == '0));
endmodule

// File: rtl/led_event_ctrl.sv
module led_event_ctrl
  import led_evt_pkg::*;
#(
  parameter int NUM_PORTS     = 5,
  parameter int LEDS_PER_PORT = 4,
  parameter int TICK_DIV      = 8192,
  parameter int ADDR_W        = 8
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic [NUM_PORTS-1:0]                link_up,
  input  logic [NUM_PORTS-1:0]                full_dup,
  input  logic [2*NUM_PORTS-1:0]              speed,
  input  logic [NUM_PORTS-1:0]                tx_act,
  input  logic [NUM_PORTS-1:0]                rx_act,
  input  logic                                reg_we,
  input  logic [ADDR_W-1:0]                   reg_addr,
  input  logic [15:0]                         reg_wdata,
  output logic [15:0]                         reg_rdata,
  output logic [NUM_PORTS*LEDS_PER_PORT-1:0]  led_pin
);
  localparam int NUM_LEDS = NUM_PORTS * LEDS_PER_PORT;

  logic                    tick;
  logic                    blink_clr;
  led_cfg_t [NUM_LEDS-1:0] eff_cfg;

  led_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (tick)
  );

  led_regfile #(
    .NUM_PORTS    (NUM_PORTS),
    .LEDS_PER_PORT(LEDS_PER_PORT),
    .ADDR_W       (ADDR_W)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_we   (reg_we),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .eff_cfg  (eff_cfg),
    .blink_clr(blink_clr)
  );

  generate
    for (genvar g = 0; g < NUM_LEDS; g++) begin : g_lane
      localparam int P = g / LEDS_PER_PORT;
      led_lane u_lane (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick),
        .clr  (blink_clr),
        .cfg  (eff_cfg[g]),
        .up   (link_up[P]),
        .fd   (full_dup[P]),
        .spd  (speed[2*P +: 2]),
        .tx   (tx_act[P]),
        .rx   (rx_act[P]),
        .pin  (led_pin[g])
      );
    end
  endgenerate
endmodule

// File: tb/led_event_ctrl_tb.sv
module led_event_ctrl_tb;
  localparam int NP = 5;
  localparam int NL = 20;
  localparam int TD = 4;

  logic clk = 0;
  logic rst_n = 0;
  logic [NP-1:0]   link_up = '0, full_dup = '0, tx_act = '0, rx_act = '0;
  logic [2*NP-1:0] speed = '1;
  logic        reg_we = 0;
  logic [7:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [NL-1:0] led_pin;

  always #2.5 clk = ~clk;

  led_event_ctrl #(.TICK_DIV(TD)) u_dut (
    .clk(clk), .rst_n(rst_n), .link_up(link_up), .full_dup(full_dup), .speed(speed),
    .tx_act(tx_act), .rx_act(rx_act), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .led_pin(led_pin)
  );

  int checks = 0, errors = 0, cyc = 0;
  string cur_req = "R1";

  // reference model state
  logic [15:0] m_on[NL], m_blk[NL], m_ond[NL], m_bd[NL];
  logic [15:0] d_on, d_blk, d_ond, d_bd, m_clr;
  logic [3:0]  m_sel[NP];
  bit          m_act[NL], m_arm[NL];
  int          m_cnt[NL];
  logic [NL-1:0] m_pin;
  int          m_pre;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp,
                     input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic bit ref_steady(logic [15:0] w, bit up, bit fd, int sp);
    bit h;
    h = w[6];
    if (!up) begin
      if (w[3]) h = 1;
    end else begin
      if (w[5] && !fd) h = 1;
      if (w[4] && fd)  h = 1;
      if (w[2] && sp == 0) h = 1;
      if (w[1] && sp == 1) h = 1;
      if (w[0] && sp == 2) h = 1;
    end
    return h;
  endfunction

  function automatic bit ref_flash(logic [15:0] w, bit up, int sp, bit tx, bit rx);
    bit h;
    h = w[9];
    if (up) begin
      case (sp)
        0: if ((w[5] && rx) || (w[4] && tx)) h = 1;
        1: if ((w[3] && rx) || (w[2] && tx)) h = 1;
        2: if ((w[1] && rx) || (w[0] && tx)) h = 1;
        default: ;
      endcase
    end
    return h;
  endfunction

  function automatic logic [15:0] ref_read(int a);
    int i, k;
    if (a < 128) begin
      i = a / 4; k = a % 4;
      if (i >= NL) return 0;
      case (k) 0: return m_on[i]; 1: return m_blk[i]; 2: return m_ond[i]; default: return m_bd[i]; endcase
    end
    if (a - 128 < NP) return 16'(m_sel[a-128]);
    if (a == 136) return m_clr;
    if (a >= 140 && a <= 143) begin
      case (a - 140) 0: return d_on; 1: return d_blk; 2: return d_ond; default: return d_bd; endcase
    end
    return 0;
  endfunction

  task automatic ref_write(int a, logic [15:0] d);
    int i, k;
    if (a < 128) begin
      i = a / 4; k = a % 4;
      if (i < NL) case (k)
        0: m_on[i] = d; 1: m_blk[i] = d; 2: m_ond[i] = d;
        default: begin m_bd[i] = d; m_ond[i] = d / 2; end
      endcase
    end else if (a - 128 < NP) m_sel[a-128] = d[3:0];
    else if (a == 136) m_clr = d;
    else if (a >= 140 && a <= 143) case (a - 140)
      0: d_on = d; 1: d_blk = d; 2: d_ond = d;
      default: begin d_bd = d; d_ond = d / 2; end
    endcase
  endtask

  // cycle model: pin from old state, then flash state, then register write
  always @(posedge clk) begin
    if (!rst_n) begin
      m_pre = 0; m_pin = '1; m_clr = 0;
      d_on = 0; d_blk = 0; d_ond = 0; d_bd = 0;
      for (int p = 0; p < NP; p++) m_sel[p] = 0;
      for (int i = 0; i < NL; i++) begin
        m_on[i] = 0; m_blk[i] = 0; m_ond[i] = 0; m_bd[i] = 0;
        m_act[i] = 0; m_arm[i] = 0; m_cnt[i] = 0;
      end
    end else begin
      bit tk;
      tk = (m_pre == TD - 1);
      m_pre = tk ? 0 : m_pre + 1;
      for (int i = 0; i < NL; i++) begin
        int p, sp, ond, bd;
        logic [15:0] ow, bw;
        bit own, up, lit, ev;
        p = i / 4; own = m_sel[p][i % 4];
        ow = own ? m_on[i] : d_on;   bw = own ? m_blk[i] : d_blk;
        ond = own ? m_ond[i] : d_ond; bd = own ? m_bd[i] : d_bd;
        up = link_up[p]; sp = int'(speed[2*p +: 2]);
        lit = m_act[i] ? (m_cnt[i] < ond) : ref_steady(ow, up, full_dup[p], sp);
        if (!ow[15]) m_pin[i] = !ow[14];
        else         m_pin[i] = ow[14] ? lit : !lit;
        ev = ref_flash(bw, up, sp, tx_act[p], rx_act[p]);
        if (m_clr != 0 || bd == 0) begin
          m_act[i] = 0; m_arm[i] = 0; m_cnt[i] = 0;
        end else if (!m_act[i]) begin
          if (ev) begin m_act[i] = 1; m_arm[i] = 0; m_cnt[i] = 0; end
        end else if (tk && m_cnt[i] >= bd - 1) begin
          if (!(m_arm[i] || ev)) m_act[i] = 0;
          m_arm[i] = 0; m_cnt[i] = 0;
        end else begin
          if (ev) m_arm[i] = 1;
          if (tk) m_cnt[i]++;
        end
      end
      if (reg_we) ref_write(int'(reg_addr), reg_wdata);
    end
  end

  always @(negedge clk) if (rst_n) chk(cur_req, 32'(led_pin), 32'(m_pin), "pins vs model");

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      errors++;
      $display("FAIL %s watchdog: actual %0d cycles expected fewer", cur_req, cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(input string req, input logic [7:0] a, input logic [15:0] exp);
    reg_addr = a; #0.5;
    chk(req, 32'(reg_rdata), 32'(exp), $sformatf("read 0x%02h", a));
    chk(req, 32'(reg_rdata), 32'(ref_read(int'(a))), "read vs model");
  endtask

  task automatic idle(int n); repeat (n) @(negedge clk); endtask

  task automatic pulse(input bit is_rx, input int p);
    @(negedge clk); if (is_rx) rx_act[p] = 1; else tx_act[p] = 1;
    @(negedge clk); rx_act[p] = 0; tx_act[p] = 0;
  endtask

  initial begin
    int hi;
    idle(4);
    cur_req = "R1";
    chk("R1", 32'(led_pin), 32'hFFFFF, "pins in reset");
    rst_n = 1;
    idle(2);
    chk("R1", 32'(led_pin), 32'hFFFFF, "pins after reset");
    rd("R1", 8'h00, 0); rd("R1", 8'h8F, 0); rd("R1", 8'h80, 0);

    cur_req = "R2";
    wr(8'h1C, 16'hA5C3); rd("R2", 8'h1C, 16'hA5C3);
    wr(8'h50, 16'h1234); rd("R2", 8'h50, 0); rd("R2", 8'h4C, 0);
    wr(8'h82, 16'hFFFF); rd("R2", 8'h82, 16'h000F);
    wr(8'h82, 0); wr(8'h1C, 0);

    cur_req = "R3";
    wr(8'h03, 16'd10); rd("R3", 8'h02, 16'd5);
    wr(8'h02, 16'd2);  rd("R3", 8'h02, 16'd2);
    wr(8'h8F, 16'h61A); rd("R3", 8'h8E, 16'h30D);
    wr(8'h8F, 0); wr(8'h03, 0); wr(8'h02, 0);

    cur_req = "R5";
    wr(8'h80, 16'h3);
    link_up[0] = 1; full_dup[0] = 1; speed[1:0] = 2'd2;
    wr(8'h00, 16'hC001); idle(3); chk("R5", 32'(led_pin[0]), 1, "1000M link lit");
    speed[1:0] = 2'd1; idle(2); chk("R5", 32'(led_pin[0]), 0, "100M not selected");
    wr(8'h00, 16'hC002); idle(2); chk("R5", 32'(led_pin[0]), 1, "100M link lit");
    wr(8'h00, 16'hC010); idle(2); chk("R5", 32'(led_pin[0]), 1, "full duplex lit");
    full_dup[0] = 0; idle(2); chk("R5", 32'(led_pin[0]), 0, "half duplex not selected");
    wr(8'h00, 16'hC020); idle(2); chk("R5", 32'(led_pin[0]), 1, "half duplex lit");
    cur_req = "R4";
    wr(8'h00, 16'h8008); link_up[0] = 0; idle(2);
    chk("R4", 32'(led_pin[0]), 0, "active-low link-down lit");
    wr(8'h00, 16'h4008); idle(2); chk("R4", 32'(led_pin[0]), 0, "disabled, pol high");
    wr(8'h00, 16'h0040); idle(2); chk("R4", 32'(led_pin[0]), 1, "disabled, pol low");
    link_up[0] = 1; full_dup[0] = 1; speed[1:0] = 2'd2;

    cur_req = "R6";
    wr(8'h04, 16'hC000); wr(8'h05, 16'h0002); wr(8'h07, 16'd6);
    pulse(0, 0); idle(8); chk("R6", 32'(led_pin[1]), 0, "tx strobe not selected");
    cur_req = "R7";
    pulse(1, 0); @(negedge clk); chk("R7", 32'(led_pin[1]), 1, "lit after rx strobe");
    for (int j = 0; j < 6; j++) begin pulse(1, 0); idle(8); end
    idle(60); chk("R7", 32'(led_pin[1]), 0, "back to steady");
    cur_req = "R6";
    speed[1:0] = 2'd1; pulse(1, 0); idle(10);
    chk("R6", 32'(led_pin[1]), 0, "speed mismatch ignored");
    speed[1:0] = 2'd2;

    cur_req = "R8";
    wr(8'h07, 0); wr(8'h05, 16'h0200); idle(30);
    chk("R8", 32'(led_pin[1]), 0, "zero period steady");

    cur_req = "R9";
    wr(8'h8C, 16'hC001); idle(2);
    chk("R9", 32'(led_pin[2]), 1, "default set used");
    chk("R9", 32'(led_pin[4]), 0, "default on port 1 link down");
    wr(8'h80, 16'h7); idle(2);
    chk("R9", 32'(led_pin[2]), 1, "own zero settings -> disabled high");

    cur_req = "R10";
    wr(8'h07, 16'd8); idle(20);
    wr(8'h88, 16'h1F); idle(3);
    for (int j = 0; j < 12; j++) begin
      @(negedge clk); chk("R10", 32'(led_pin[1]), 0, "held steady under clear");
    end
    wr(8'h88, 0); idle(20);

    cur_req = "R11";
    wr(8'h07, 16'd2); wr(8'h06, 16'd1); idle(24);
    hi = 0;
    for (int j = 0; j < 32; j++) begin @(negedge clk); hi += int'(led_pin[1]); end
    chk("R11", 32'(hi), 16, "lit cycles in 32 with period 2 ticks");

    cur_req = "R7";
    for (int i = 0; i < NL; i++) begin
      wr(8'(i*4),   16'($urandom));
      wr(8'(i*4+1), 16'($urandom) & 16'h023F);
      wr(8'(i*4+3), 16'($urandom_range(0, 9)));
    end
    for (int p = 0; p < NP; p++) wr(8'(128+p), 16'($urandom));
    for (int j = 0; j < 2500; j++) begin
      @(negedge clk);
      link_up = NP'($urandom); full_dup = NP'($urandom); speed = (2*NP)'($urandom);
      tx_act = NP'($urandom) & NP'($urandom); rx_act = NP'($urandom) & NP'($urandom);
      if (j % 97 == 0) begin
        reg_we = 1; reg_addr = 8'($urandom_range(0, 79)); reg_wdata = 16'($urandom);
      end else if (j % 401 == 0) begin
        reg_we = 1; reg_addr = 8'h88; reg_wdata = 16'(j % 2);
      end else reg_we = 0;
    end
    @(negedge clk); reg_we = 0; tx_act = '0; rx_act = '0;
    idle(10);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule